// File: doc/BRIEF.md
# Serial PCM Word Deframer with Even Parity Check

This block sits at the receiving end of a serial pulse-code-modulated line. It recovers 7-bit sample codes from the line and hands each one to a reconstruction stage. Each word on the line occupies ten bit slots. The first slot is a low start bit. The next seven slots carry the code, least significant bit first. The last two slots are stop slots. An enable that pulses sixteen times per bit slot paces the block, and each slot is read once, at its centre.

The block runs in one of two timing modes. In shared-timing mode the encoder supplies a word-start marker, and the block uses that marker to find word boundaries. In self-timed mode the block hunts for a high-to-low transition on the line. It then confirms the start bit at mid-slot and uses the stop slots to check that it is aligned. When parity checking is on, the first stop slot is read as an even parity bit over the code. The block reports each good code with a one-cycle valid pulse. It raises one-cycle flags for a parity error and for a framing error, and it keeps the last good code on its output.

Top module: `pcm_deframer`

## Requirements
- R1: A word is ten slots of 16 `os_tick` pulses each. Slot 0 is the start bit. Slots 1 to 7 carry code bits 0 to 6 in that order. Slot 8 is the first stop slot and slot 9 is the second stop slot. Each slot is sampled on the ninth tick of the slot. Counting the word's first tick as tick 0, slot k is sampled on tick 16k+8.
- R2: In self-timed mode (`sync_mode`=0), a word begins on a tick where `line_in` is low and the line was high on the previous tick.
- R3: In self-timed mode, if the line is high when the start slot is sampled, the word is discarded. No valid pulse and no flag is produced, and the block returns to hunting.
- R4: In shared-timing mode (`sync_mode`=1), a word begins only on a tick that coincides with `word_start`. Line transitions without the marker have no effect. If the line is high when the start slot is sampled, `frame_err` pulses.
- R5: With `parity_en`=1, slot 8 is the parity bit. If the seven code bits and that bit together hold an odd number of ones, `parity_err` pulses.
- R6: With `parity_en`=0, the value in slot 8 has no effect on any output.
- R7: If slot 9 is sampled low, `frame_err` pulses and the block returns to hunting. A word that is misaligned because its start bit was lost ends in a framing error, and the next clean word after idle line is decoded correctly.
- R8: A word with no error gives `code_valid` high for exactly one clock, with the code on `code_out`. `code_out` changes only with `code_valid`, so it keeps the last good code while a flag is raised. Flags last one clock and never coincide with `code_valid`. All results appear one clock after the tick that samples slot 9.
- R9: After reset, `code_out`, `code_valid`, `parity_err` and `frame_err` are 0 and the block is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversample enable, 16 pulses per bit slot |
| line_in | input | 1 | Serial line, synchronous to clk |
| sync_mode | input | 1 | 1: shared-timing mode, 0: self-timed mode |
| word_start | input | 1 | Shared word-start marker, coincident with the first tick of a word |
| parity_en | input | 1 | 1: slot 8 is checked as even parity |
| code_out | output | 7 | Last good code |
| code_valid | output | 1 | One-clock pulse when a new code is on code_out |
| parity_err | output | 1 | One-clock pulse: parity mismatch |
| frame_err | output | 1 | One-clock pulse: bad stop slot, or high start slot in shared-timing mode |

## Verification
The bench sends a word whose start bit is missing, so the receiver locks onto a data edge. A design that does not check the final stop slot would pass the misaligned garbage off as a valid code. A short low glitch is sent to show that the start is confirmed at mid-slot; a design that trusts the edge alone would emit a spurious word. In shared-timing mode, a full frame is sent without the marker, and a marked frame follows a low slot that has no falling edge. These catch a receiver that still hunts for edges in that mode. Parity is checked with the slot-8 value both right and wrong, with the check both on and off, and together with a bad stop slot. A design that lets the output code change on an error, or that checks parity when it is disabled, is exposed by the held-code comparison.

// File: rtl/pcm_deframer_pkg.sv
package pcm_deframer_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_START = 2'd1,
        ST_BITS  = 2'd2
    } dfr_state_e;
endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic active,
    output logic strobe
);
    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        strobe = 1'b0;
        if (tick) begin
            if (restart) begin
                cnt_d = CW'(HALF - 1);
            end else if (active) begin
                if (cnt_q == '0) begin
                    strobe = 1'b1;
                    cnt_d  = CW'(OVS - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_STROBE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (cnt_q == CW'(OVS - 1))); // R1

endmodule

// File: rtl/pcm_parity_chk.sv
module pcm_parity_chk #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits,
    output logic         odd
);
    assign odd = ^bits;
endmodule

// File: rtl/pcm_deframer.sv
module pcm_deframer
    import pcm_deframer_pkg::*;
#(
    parameter int DATA_W = 7,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              line_in,
    input  logic              sync_mode,
    input  logic              word_start,
    input  logic              parity_en,
    output logic [DATA_W-1:0] code_out,
    output logic              code_valid,
    output logic              parity_err,
    output logic              frame_err
);
    localparam int SLOT_W    = $clog2(DATA_W + 3);
    localparam int STOP1_IDX = DATA_W + 1;

    typedef struct packed {
        dfr_state_e        state;
        logic [SLOT_W-1:0] slot;
        logic [DATA_W-1:0] shreg;
        logic              stop1;
        logic              line_prev;
        logic [DATA_W-1:0] code;
        logic              valid;
        logic              perr;
        logic              ferr;
    } dfr_regs_t;

    dfr_regs_t r_d, r_q;

    logic strobe;
    logic restart;
    logic active;
    logic begin_word;
    logic par_odd;

    pcm_slot_timer #(.OVS(OVS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .restart (restart),
        .active  (active),
        .strobe  (strobe)
    );

    pcm_parity_chk #(.W(DATA_W + 1)) u_parity (
        .bits (({r_q.stop1, r_q.shreg})),
        .odd  (par_odd)
    );

    assign begin_word = os_tick && (sync_mode ? word_start
                                              : (r_q.line_prev && !line_in));
    assign restart    = (r_q.state == ST_HUNT) && begin_word;
    assign active     = (r_q.state != ST_HUNT);

    always_comb begin
        logic perr_now;
        logic ferr_now;
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.perr  = 1'b0;
        r_d.ferr  = 1'b0;
        perr_now  = 1'b0;
        ferr_now  = 1'b0;
        if (os_tick) r_d.line_prev = line_in;

        unique case (r_q.state)
            ST_HUNT: begin
                if (begin_word) r_d.state = ST_START;
            end
            ST_START: begin
                if (strobe) begin
                    if (!line_in) begin
                        r_d.state = ST_BITS;
                        r_d.slot  = SLOT_W'(1);
                    end else begin
                        r_d.state = ST_HUNT;
                        r_d.ferr  = sync_mode;
                    end
                end
            end
            ST_BITS: begin
                if (strobe) begin
                    if (r_q.slot <= SLOT_W'(DATA_W)) begin
                        r_d.shreg = {line_in, r_q.shreg[DATA_W-1:1]};
                        r_d.slot  = r_q.slot + 1'b1;
                    end else if (r_q.slot == SLOT_W'(STOP1_IDX)) begin
                        r_d.stop1 = line_in;
                        r_d.slot  = r_q.slot + 1'b1;
                    end else begin
                        perr_now  = parity_en && par_odd;
                        ferr_now  = !line_in;
                        r_d.state = ST_HUNT;
                        r_d.perr  = perr_now;
                        r_d.ferr  = ferr_now;
                        if (!perr_now && !ferr_now) begin
                            r_d.valid = 1'b1;
                            r_d.code  = r_q.shreg;
                        end
                    end
                end
            end
            default: r_d.state = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.state     <= ST_HUNT;
            r_q.line_prev <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign code_out   = r_q.code;
    assign code_valid = r_q.valid;
    assign parity_err = r_q.perr;
    assign frame_err  = r_q.ferr;

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> !code_valid); // R8
    AST_VALID_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> !(parity_err || frame_err)); // R8
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |-> $stable(code_out)); // R8
    AST_PERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err |-> $past(parity_en)); // R6
    AST_HUNT_AFTER_FERR: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> (r_q.state == ST_HUNT)); // R7
    AST_SYNC_NEEDS_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HUNT && sync_mode && !word_start) |=> (r_q.state == ST_HUNT)); // R4

endmodule

// File: tb/pcm_deframer_tb.sv
`timescale 1ns/1ps
module pcm_deframer_tb;
    localparam int DW  = 7;
    localparam int OVS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          os_tick = 1'b0;
    logic          line_in = 1'b1;
    logic          sync_mode = 1'b0;
    logic          word_start = 1'b0;
    logic          parity_en = 1'b0;
    logic [DW-1:0] code_out;
    logic          code_valid, parity_err, frame_err;

    always #2.5 clk = ~clk;

    pcm_deframer #(.DATA_W(DW), .OVS(OVS)) u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .line_in(line_in),
        .sync_mode(sync_mode), .word_start(word_start), .parity_en(parity_en),
        .code_out(code_out), .code_valid(code_valid),
        .parity_err(parity_err), .frame_err(frame_err)
    );

    typedef struct {
        logic [2:0]    kind;   // {ferr, perr, valid}
        logic [DW-1:0] code;
        string         req;
    } exp_t;

    exp_t          exp_q[$];
    int            checks = 0;
    int            failures = 0;
    logic [DW-1:0] last_good = '0;
    bit            done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    task automatic expect_item(input logic [2:0] kind, input logic [DW-1:0] code,
                               input string req);
        exp_t e;
        e.kind = kind;
        e.req  = req;
        if (kind == 3'b001) begin
            e.code    = code;
            last_good = code;
        end else begin
            e.code = last_good;
        end
        exp_q.push_back(e);
    endtask

    task automatic tick_once(input logic b, input logic ws);
        @(negedge clk);
        line_in    = b;
        word_start = ws;
        os_tick    = 1'b1;
        @(negedge clk);
        os_tick    = 1'b0;
        word_start = 1'b0;
    endtask

    task automatic send_slot(input logic b, input logic ws);
        for (int t = 0; t < OVS; t++) tick_once(b, ws && (t == 0));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send_slot(1'b1, 1'b0);
    endtask

    task automatic send_word(input logic [DW-1:0] d, input logic s8,
                             input logic s9, input logic ws);
        send_slot(1'b0, ws);
        for (int i = 0; i < DW; i++) send_slot(d[i], 1'b0);
        send_slot(s8, 1'b0);
        send_slot(s9, 1'b0);
        idle(2);
    endtask

    task automatic drained(input string req);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, req, "pending results", exp_q.size(), 0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done && (code_valid || parity_err || frame_err)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected result",
                      {29'd0, frame_err, parity_err, code_valid}, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({frame_err, parity_err, code_valid} == e.kind, e.req, "kind",
                      {29'd0, frame_err, parity_err, code_valid}, {29'd0, e.kind});
                check(code_out == e.code, e.req, "code_out", code_out, e.code);
            end
        end
    end

    // watchdog
    initial begin
        int cyc;
        cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                failures++;
                checks++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check({code_out, code_valid, parity_err, frame_err} == '0, "R9", "reset outputs",
              {code_out, code_valid, parity_err, frame_err}, 0);
        rst_n = 1'b1;
        idle(2);

        // R1 R2: self-timed decoding, parity off
        expect_item(3'b001, 7'h55, "R1"); send_word(7'h55, 1'b1, 1'b1, 1'b0);
        expect_item(3'b001, 7'h00, "R2"); send_word(7'h00, 1'b1, 1'b1, 1'b0);
        expect_item(3'b001, 7'h7F, "R1"); send_word(7'h7F, 1'b1, 1'b1, 1'b0);
        expect_item(3'b001, 7'h2A, "R2"); send_word(7'h2A, 1'b1, 1'b1, 1'b0);
        // R6: slot 8 low, parity disabled
        expect_item(3'b001, 7'h13, "R6"); send_word(7'h13, 1'b0, 1'b1, 1'b0);
        expect_item(3'b001, 7'h14, "R6"); send_word(7'h14, ^7'h14 ^ 1'b1, 1'b1, 1'b0);
        drained("R6");

        // R5: parity enabled
        parity_en = 1'b1;
        expect_item(3'b001, 7'h0F, "R5"); send_word(7'h0F, ^7'h0F, 1'b1, 1'b0);
        expect_item(3'b010, 7'h00, "R5"); send_word(7'h0E, ~(^7'h0E), 1'b1, 1'b0);
        expect_item(3'b110, 7'h00, "R7"); send_word(7'h31, ~(^7'h31), 1'b0, 1'b0);
        parity_en = 1'b0;

        // R7: bad second stop slot
        expect_item(3'b100, 7'h00, "R7"); send_word(7'h21, 1'b1, 1'b0, 1'b0);
        expect_item(3'b001, 7'h48, "R7"); send_word(7'h48, 1'b1, 1'b1, 1'b0);

        // R3: short low glitch is rejected
        for (int t = 0; t < 4; t++) tick_once(1'b0, 1'b0);
        for (int t = 0; t < 12; t++) tick_once(1'b1, 1'b0);
        idle(2);
        drained("R3");
        expect_item(3'b001, 7'h44, "R3"); send_word(7'h44, 1'b1, 1'b1, 1'b0);

        // R7: lost start bit -> misaligned word ends in framing error
        expect_item(3'b100, 7'h00, "R7");
        send_slot(1'b1, 1'b0);
        send_slot(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) send_slot(1'b1, 1'b0);
        send_slot(1'b0, 1'b0);
        idle(3);
        expect_item(3'b001, 7'h66, "R7"); send_word(7'h66, 1'b1, 1'b1, 1'b0);
        drained("R7");

        // R4: shared-timing mode
        sync_mode = 1'b1;
        send_word(7'h11, 1'b1, 1'b1, 1'b0);       // no marker: ignored
        drained("R4");
        expect_item(3'b001, 7'h3C, "R4"); send_word(7'h3C, 1'b1, 1'b1, 1'b1);
        send_slot(1'b0, 1'b0);                     // low slot, no edge at word start
        expect_item(3'b001, 7'h5A, "R4"); send_word(7'h5A, 1'b1, 1'b1, 1'b1);
        expect_item(3'b100, 7'h00, "R4");
        send_slot(1'b1, 1'b1);                     // marker with high start slot
        idle(3);
        drained("R4");
        sync_mode = 1'b0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule